// File: doc/BRIEF.md
# Transparent Two-Read One-Write Register File

This block is the architectural register store of a five-stage integer pipeline. It holds a set of general-purpose words (32 entries of 32 bits by default). The decode stage addresses it through two read ports. The write-back stage addresses it through one write port.

Both read ports are combinational, so the decode stage sees its operands in the same cycle it presents the addresses. The write port commits on the rising clock edge, and only while the write enable is high.

The file is transparent. When a read address matches the address being written in the current cycle, that port returns the incoming write data instead of the stored word. A write-back and the decode of a later instruction can therefore share one cycle, and the decode stage still gets the fresh value. Entry 0 is a hard-wired zero. It never stores, never bypasses and always reads as zero.

Top module: `gpr_bypass_file`

## Requirements
- R1: Each read port returns, combinationally, the stored word of the entry named by its address.
- R2: A write commits to the addressed entry on the rising clock edge when `wr_en` is 1. When `wr_en` is 0, no entry changes.
- R3: Port A returns `wr_data` in the same cycle when `wr_en` is 1, `rd_addr_a` equals `wr_addr`, and the address is not 0.
- R4: Port B returns `wr_data` in the same cycle under the same condition, using `rd_addr_b`.
- R5: When `wr_en` is 0, a port whose address equals `wr_addr` returns the stored word, not `wr_data`.
- R6: Address 0 always reads as all zeros on both ports. Writes to it are discarded and never bypassed.
- R7: When both read addresses equal a nonzero write address with `wr_en` 1, both ports return `wr_data` in that cycle.
- R8: Driving `rst_n` low clears every entry to zero asynchronously. The reset is released synchronously to `clk` by the surrounding logic.
- R9: The two ports are independent: different addresses on A and B return the two different stored words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset that clears all entries |
| rd_addr_a | input | ADDR_W (5) | Read port A address |
| rd_data_a | output | DATA_W (32) | Read port A data |
| rd_addr_b | input | ADDR_W (5) | Read port B address |
| rd_data_b | output | DATA_W (32) | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | DATA_W (32) | Write data |

## Verification
The hardest case to reach from the ports is the same-cycle overlap: a read address equal to the write address while the enable is high. The overlap must be tested on each port alone, on both ports at once, at entry 0, and with the enable low.

The bench makes these overlaps deliberate. During every write it points the read ports at the entry being written, and it compares the combinational outputs before the edge against the new data. After the edge it reads the entry back to confirm that the stored value matches.

A second pass repeats the writes with one port aimed elsewhere. A third pass holds the enable low while the addresses still match, so that a bypass condition which ignores the enable shows up as a wrong value.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  // Source of a read port result
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_BYPASS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/gprf_store.sv
module gprf_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] stored_a,
  output logic [DATA_W-1:0] stored_b
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  // Entry 0 holds no flops
  assign regs_q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
    logic entry_en;
    always_comb begin
      entry_en = wr_en && (wr_addr == ADDR_W'(i));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (entry_en) begin
        regs_q[i] <= wr_data;
      end
    end
  end

  assign stored_a = regs_q[rd_addr_a];
  assign stored_b = regs_q[rd_addr_b];
endmodule

// File: rtl/gprf_read_port.sv
module gprf_read_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] stored,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  import gprf_pkg::*;

  rd_src_e src;

  always_comb begin
    if (rd_addr == '0) begin
      src = SRC_ZERO;
    end else if (wr_en && (wr_addr == rd_addr)) begin
      src = SRC_BYPASS;
    end else begin
      src = SRC_STORE;
    end
  end

  always_comb begin
    case (src)
      SRC_BYPASS: rd_data = wr_data;
      SRC_STORE:  rd_data = stored;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpr_bypass_file.sv
module gpr_bypass_file #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NPORTS = 2;

  logic [DATA_W-1:0] stored_a, stored_b;
  logic [ADDR_W-1:0] port_addr   [NPORTS];
  logic [DATA_W-1:0] port_stored [NPORTS];
  logic [DATA_W-1:0] port_data   [NPORTS];

  gprf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .stored_a(stored_a), .stored_b(stored_b)
  );

  assign port_addr[0]   = rd_addr_a;
  assign port_addr[1]   = rd_addr_b;
  assign port_stored[0] = stored_a;
  assign port_stored[1] = stored_b;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gprf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rp (
      .rd_addr(port_addr[p]), .stored(port_stored[p]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(port_data[p])
    );
  end

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];
endmodule

// File: rtl/gprf_checker.sv
module gprf_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  // Set one cycle after reset release so $past never sees reset-time inputs
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_zero_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  assert_zero_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  assert_bypass_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_a && rd_addr_a != '0) |-> (rd_data_a == wr_data));
  assert_bypass_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_b && rd_addr_b != '0) |-> (rd_data_b == wr_data));

  // R2: a write is visible from the next cycle on
  assert_commit_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(wr_en) && $past(wr_addr) != '0 && rd_addr_a == $past(wr_addr)
     && !(wr_en && wr_addr == rd_addr_a)) |-> (rd_data_a == $past(wr_data)));

  // R5: with no write, a held address reads a steady value
  assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(wr_en) && !wr_en && $stable(rd_addr_a)) |-> $stable(rd_data_a));
endmodule

bind gpr_bypass_file gprf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/gpr_bypass_file_tb.sv
module gpr_bypass_file_tb;
  localparam int N  = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
  logic          wr_en;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  gpr_bypass_file u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return (32'(i) * 32'h9E37_79B1) ^ (32'(salt) * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present inputs at the falling edge, return 1 ns later to check
  task automatic drive(input logic we, input int wa, input logic [DW-1:0] wd,
                       input int ra, input int rb);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_addr_a = AW'(ra); rd_addr_b = AW'(rb);
    #1;
  endtask

  task automatic commit(input logic we, input int wa, input logic [DW-1:0] wd);
    if (we && wa != 0) model[wa] = wd;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    #2 rst_n = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R8: everything reads zero after reset
    for (int i = 0; i < N; i++) begin
      drive(1'b0, 0, '0, i, N - 1 - i);
      chk("R8 port A after reset", rd_data_a, '0);
      chk("R8 port B after reset", rd_data_b, '0);
    end

    // R3 R4 R7 R6: both ports aimed at the entry being written
    for (int i = 0; i < N; i++) begin
      drive(1'b1, i, pat(i, 1), i, i);
      chk(i == 0 ? "R6 port A no bypass at 0" : "R3 R7 port A bypass", rd_data_a, i == 0 ? '0 : pat(i, 1));
      chk(i == 0 ? "R6 port B no bypass at 0" : "R4 R7 port B bypass", rd_data_b, i == 0 ? '0 : pat(i, 1));
      commit(1'b1, i, pat(i, 1));
    end

    // R1 R9 R2: read back both ports at different entries
    for (int i = 0; i < N; i++) begin
      drive(1'b0, 0, '0, i, (i + 13) % N);
      chk("R1 R2 port A readback", rd_data_a, model[i]);
      chk("R9 port B readback", rd_data_b, model[(i + 13) % N]);
    end

    // R5: enable low with matching addresses and new data
    for (int i = 0; i < N; i++) begin
      drive(1'b0, i, ~pat(i, 7), i, i);
      chk("R5 port A no bypass when disabled", rd_data_a, model[i]);
      chk("R5 port B no bypass when disabled", rd_data_b, model[i]);
    end
    for (int i = 0; i < N; i++) begin
      drive(1'b0, 0, '0, i, i);
      chk("R2 no change without enable", rd_data_a, model[i]);
    end

    // R3 alone, port B on another entry; then R4 alone
    for (int i = 0; i < N; i++) begin
      drive(1'b1, i, pat(i, 3), i, (i + 5) % N);
      chk("R3 port A single bypass", rd_data_a, i == 0 ? '0 : pat(i, 3));
      chk("R9 port B unaffected", rd_data_b, model[(i + 5) % N]);
      commit(1'b1, i, pat(i, 3));
    end
    for (int i = 0; i < N; i++) begin
      drive(1'b1, i, pat(i, 4), (i + 9) % N, i);
      chk("R4 port B single bypass", rd_data_b, i == 0 ? '0 : pat(i, 4));
      chk("R9 port A unaffected", rd_data_a, model[(i + 9) % N]);
      commit(1'b1, i, pat(i, 4));
    end

    // R6: entry 0 stays zero after a write to it
    drive(1'b1, 0, 32'hFFFF_FFFF, 0, 0);
    drive(1'b0, 0, '0, 0, 0);
    chk("R6 port A entry 0 after write", rd_data_a, '0);
    chk("R6 port B entry 0 after write", rd_data_b, '0);

    // R8: reset in mid-run clears the stored words
    do_reset();
    for (int i = 0; i < N; i++) begin
      drive(1'b0, 0, '0, i, i);
      chk("R8 cleared after second reset", rd_data_a, '0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule